// File: doc/BRIEF.md
# Precise Trap Commit Unit

This block gathers exception conditions for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It resolves them at one commit point, the memory stage. Each stage reports its own fault flag. The block keeps a small record for every instruction in flight, holding a valid bit, an exception bit and a cause code. The record travels down the pipe with the instruction. Nothing is acted on until the instruction reaches commit.

At commit the block decides whether a trap is taken. A synchronised external interrupt request outranks any synchronous fault. When a trap is taken, the block kills fetch, decode, execute and memory in the same cycle and sends a one-cycle redirect with a fixed handler address. It captures the trap code and the PC of the committing instruction into its cause and exception-PC registers. The writeback kill is raised one cycle later, when the trapping instruction has moved into writeback. The older instruction already in writeback therefore completes.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset, redirect_o, kill_o, kill_wb_o, cause_o and epc_o are all zero.
- R2: A fault flag raised in any stage produces no redirect while its instruction is in fetch, decode or execute. The redirect appears in the cycle the instruction sits in the memory stage, three cycles after it was fetched.
- R3: If one instruction is flagged in several stages, the recorded cause is the one from the earliest stage.
- R4: A synchronised interrupt that is pending when a valid instruction commits takes the trap with the interrupt code, even if that instruction also carries a synchronous fault.
- R5: Cause codes are 4 bits: fetch address fault = 1, illegal opcode = 2, arithmetic overflow = 3, data address fault = 4, interrupt = 8.
- R6: cause_o and epc_o change only on the clock edge that ends a trap cycle. epc_o then holds the m_pc_i value of that cycle. Otherwise both hold their values.
- R7: In a trap cycle, redirect_o is 1, all four bits of kill_o are 1 (bit 0 fetch, 1 decode, 2 execute, 3 memory), and handler_pc_o equals the HANDLER_PC parameter. redirect_o is never high in two consecutive cycles.
- R8: kill_wb_o is 0 in the trap cycle, so the older instruction in writeback completes. It is 1 in exactly the following cycle.
- R9: Younger instructions flushed by a trap never raise a later trap, even if they carried fault flags.
- R10: A bubble (invalid slot) never takes a synchronous exception. Fault flags on bubbles are ignored.
- R11: irq_i is used only after passing two flip-flops. An interrupt is taken only when a valid instruction is at commit. Bubbles at commit leave it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid_i | input | 1 | Fetch slot holds a real instruction |
| f_fault_i | input | 1 | Fetch address fault for the fetch slot |
| d_illegal_i | input | 1 | Illegal opcode for the decode slot |
| e_ovf_i | input | 1 | Arithmetic overflow for the execute slot |
| m_dfault_i | input | 1 | Data address fault for the memory slot |
| m_pc_i | input | XLEN | PC of the instruction in the memory stage |
| irq_i | input | 1 | Asynchronous interrupt request (level) |
| redirect_o | output | 1 | Send fetch to the handler this cycle |
| handler_pc_o | output | XLEN | Trap handler address |
| kill_o | output | 4 | Flush for fetch, decode, execute, memory |
| kill_wb_o | output | 1 | Suppress writeback of the trapping instruction |
| cause_o | output | 4 | Cause register |
| epc_o | output | XLEN | Exception PC register |

## Verification
redirect_o, kill_o and handler_pc_o are combinational at commit. They are due in the cycle an instruction fetched in cycle t occupies the memory stage, t+3, and are sampled there, one time unit after the inputs are driven on the falling edge. cause_o, epc_o and kill_wb_o are due one cycle later and are sampled in cycle t+4. kill_wb_o is also checked low again in t+5. Interrupts are checked against a two-edge synchroniser delay: a request raised while instructions commit in consecutive cycles must miss the first two of them and hit the third.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;
  localparam int CW   = 4;
  localparam int NSTG = 4;  // fetch, decode, execute, memory

  typedef logic [CW-1:0] cause_t;

  localparam cause_t C_NONE  = 4'd0;
  localparam cause_t C_FETCH = 4'd1;
  localparam cause_t C_ILL   = 4'd2;
  localparam cause_t C_OVF   = 4'd3;
  localparam cause_t C_DATA  = 4'd4;
  localparam cause_t C_IRQ   = 4'd8;

  typedef struct packed {
    logic   valid;
    logic   exc;
    cause_t code;
  } exc_rec_t;

  // Code raised by the fault flag of stage k.
  function automatic cause_t stage_code(input int k);
    case (k)
      0:       stage_code = C_FETCH;
      1:       stage_code = C_ILL;
      2:       stage_code = C_OVF;
      default: stage_code = C_DATA;
    endcase
  endfunction

  // Add a stage's flag to a record; an earlier recorded fault is kept.
  function automatic exc_rec_t fold(input exc_rec_t r, input logic flag, input cause_t code);
    fold = r;
    if (r.valid && !r.exc && flag) begin
      fold.exc  = 1'b1;
      fold.code = code;
    end
  endfunction

  // Interrupt outranks any synchronous fault at commit.
  function automatic cause_t pick_cause(input logic irq, input exc_rec_t r);
    pick_cause = irq ? C_IRQ : r.code;
  endfunction
endpackage

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[DEPTH-2:0], async_i};
  end

  assign sync_o = chain[DEPTH-1];
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_commit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  exc_rec_t d,
  output exc_rec_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n || flush) q <= '0;
    else                 q <= d;
  end

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q.valid);
endmodule

// File: rtl/exc_commit_logic.sv
module exc_commit_logic
  import exc_commit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  exc_rec_t        rec,
  input  logic            irq_s,
  input  logic [XLEN-1:0] pc,
  output logic            take,
  output cause_t          cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic            kill_wb_q
);
  logic   commit_valid;
  logic   sync_exc;
  cause_t cause_next;

  assign commit_valid = rec.valid;
  assign sync_exc     = rec.exc;
  assign take         = commit_valid && (irq_s || sync_exc);
  assign cause_next   = pick_cause(irq_s, rec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q   <= C_NONE;
      epc_q     <= '0;
      kill_wb_q <= 1'b0;
    end else begin
      kill_wb_q <= take;
      if (take) begin
        cause_q <= cause_next;
        epc_q   <= pc;
      end
    end
  end

  assert_redirect_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  assert_epc_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> epc_q == $past(pc));
  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cause_q) && $stable(epc_q));
  assert_irq_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_s) |=> cause_q == C_IRQ);
  assert_wb_kill_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> kill_wb_q);
  assert_wb_kill_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !kill_wb_q);
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_commit_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            f_valid_i,
  input  logic            f_fault_i,
  input  logic            d_illegal_i,
  input  logic            e_ovf_i,
  input  logic            m_dfault_i,
  input  logic [XLEN-1:0] m_pc_i,
  input  logic            irq_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] handler_pc_o,
  output logic [3:0]      kill_o,
  output logic            kill_wb_o,
  output logic [3:0]      cause_o,
  output logic [XLEN-1:0] epc_o
);
  logic [NSTG-1:0] raise;
  exc_rec_t        held [NSTG];  // record entering stage k
  exc_rec_t        at   [NSTG];  // record after stage k's flag is added
  logic            irq_s;
  logic            take;
  cause_t          cause_w;

  assign raise   = {m_dfault_i, e_ovf_i, d_illegal_i, f_fault_i};
  assign held[0] = '{valid: f_valid_i, exc: 1'b0, code: C_NONE};

  genvar k;
  generate
    for (k = 0; k < NSTG; k++) begin : g_stage
      assign at[k] = fold(held[k], raise[k], stage_code(k));
      if (k > 0) begin : g_reg
        exc_stage_reg u_reg (
          .clk   (clk),
          .rst_n (rst_n),
          .flush (take),
          .d     (at[k-1]),
          .q     (held[k])
        );
      end
    end
  endgenerate

  exc_irq_sync #(.DEPTH(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_i),
    .sync_o  (irq_s)
  );

  exc_commit_logic #(.XLEN(XLEN)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec       (at[NSTG-1]),
    .irq_s     (irq_s),
    .pc        (m_pc_i),
    .take      (take),
    .cause_q   (cause_w),
    .epc_q     (epc_o),
    .kill_wb_q (kill_wb_o)
  );

  assign redirect_o   = take;
  assign handler_pc_o = HANDLER_PC;
  assign kill_o       = {4{take}};
  assign cause_o      = cause_w;

  assert_bubble_no_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!held[NSTG-1].valid) |-> !redirect_o);
endmodule

// File: tb/sim_exc_commit_unit.sv
`timescale 1ns/1ps
module sim_exc_commit_unit;
  localparam logic [31:0] HPC = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_valid_i = 0, f_fault_i = 0, d_illegal_i = 0, e_ovf_i = 0, m_dfault_i = 0;
  logic [31:0] m_pc_i = '0;
  logic        irq_i = 0;
  logic        redirect_o, kill_wb_o;
  logic [31:0] handler_pc_o, epc_o;
  logic [3:0]  kill_o, cause_o;

  int tests = 0, fails = 0;
  bit done = 0;

  logic        s_red, s_kwb;
  logic [3:0]  s_kill, s_cause;
  logic [31:0] s_epc, s_hpc;

  always #4 clk = ~clk;

  exc_commit_unit #(.XLEN(32), .HANDLER_PC(HPC)) u0 (
    .clk(clk), .rst_n(rst_n), .f_valid_i(f_valid_i), .f_fault_i(f_fault_i),
    .d_illegal_i(d_illegal_i), .e_ovf_i(e_ovf_i), .m_dfault_i(m_dfault_i),
    .m_pc_i(m_pc_i), .irq_i(irq_i), .redirect_o(redirect_o),
    .handler_pc_o(handler_pc_o), .kill_o(kill_o), .kill_wb_o(kill_wb_o),
    .cause_o(cause_o), .epc_o(epc_o));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample 1 ns later, wait for next falling edge.
  task automatic tick(input logic fv, input logic ff, input logic di, input logic eo,
                      input logic md, input logic [31:0] pc);
    f_valid_i = fv; f_fault_i = ff; d_illegal_i = di; e_ovf_i = eo; m_dfault_i = md; m_pc_i = pc;
    #1;
    s_red = redirect_o; s_kill = kill_o; s_kwb = kill_wb_o;
    s_cause = cause_o; s_epc = epc_o; s_hpc = handler_pc_o;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 32'h0);
  endtask

  function automatic logic [3:0] code_for(input int stg);
    case (stg)
      0: return 4'd1;
      1: return 4'd2;
      2: return 4'd3;
      default: return 4'd4;
    endcase
  endfunction

  task automatic t_reset;
    tick(0, 0, 0, 0, 0, 32'h0);
    chk("R1", "redirect", {31'b0, s_red}, 0);
    chk("R1", "kill", {28'b0, s_kill}, 0);
    chk("R1", "kill_wb", {31'b0, s_kwb}, 0);
    chk("R1", "cause", {28'b0, s_cause}, 0);
    chk("R1", "epc", s_epc, 0);
  endtask

  // One instruction with a single fault in stage stg.
  task automatic t_one(input int stg, input logic [31:0] pc);
    for (int c = 0; c < 4; c++) begin
      tick(c == 0, stg == 0 && c == 0, stg == 1 && c == 1, stg == 2 && c == 2,
           stg == 3 && c == 3, pc);
      if (c < 3) chk("R2", "early redirect", {31'b0, s_red}, 0);
    end
    chk("R2", "redirect at commit", {31'b0, s_red}, 1);
    chk("R7", "kill all", {28'b0, s_kill}, 32'hf);
    chk("R7", "handler pc", s_hpc, HPC);
    chk("R8", "kill_wb in trap cycle", {31'b0, s_kwb}, 0);
    tick(0, 0, 0, 0, 0, 32'h0);
    chk("R5", "cause code", {28'b0, s_cause}, {28'b0, code_for(stg)});
    chk("R6", "epc", s_epc, pc);
    chk("R8", "kill_wb next cycle", {31'b0, s_kwb}, 1);
    chk("R7", "redirect single", {31'b0, s_red}, 0);
    tick(0, 0, 0, 0, 0, 32'h0);
    chk("R8", "kill_wb one cycle", {31'b0, s_kwb}, 0);
    chk("R6", "epc hold", s_epc, pc);
    idle(2);
  endtask

  task automatic t_priority;
    // flagged in every stage -> fetch code wins
    tick(1, 1, 0, 0, 0, 0); tick(0, 0, 1, 0, 0, 0); tick(0, 0, 0, 1, 0, 0);
    tick(0, 0, 0, 0, 1, 32'h0000_2000);
    chk("R3", "redirect", {31'b0, s_red}, 1);
    tick(0, 0, 0, 0, 0, 0);
    chk("R3", "earliest=fetch", {28'b0, s_cause}, 1);
    idle(3);
    // decode and memory flags -> illegal code wins
    tick(1, 0, 0, 0, 0, 0); tick(0, 0, 1, 0, 0, 0); tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 32'h0000_2004);
    tick(0, 0, 0, 0, 0, 0);
    chk("R3", "earliest=decode", {28'b0, s_cause}, 2);
    idle(3);
  endtask

  task automatic t_flush;
    // A fetched c0 overflows in execute; B fetched c1 with a fetch fault, then decode flag
    tick(1, 0, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 0);
    tick(0, 0, 1, 1, 0, 0);
    tick(0, 0, 0, 0, 0, 32'h0000_3000);
    chk("R9", "A traps", {31'b0, s_red}, 1);
    tick(0, 0, 0, 0, 1, 32'h0000_3004);
    chk("R9", "B flushed, no trap", {31'b0, s_red}, 0);
    chk("R9", "cause from A", {28'b0, s_cause}, 3);
    for (int i = 0; i < 3; i++) begin
      tick(0, 0, 0, 0, 0, 0);
      chk("R9", "no late trap", {31'b0, s_red}, 0);
    end
    chk("R9", "epc from A", s_epc, 32'h0000_3000);
  endtask

  task automatic t_bubble;
    logic [3:0]  c0;
    logic [31:0] e0;
    c0 = s_cause; e0 = s_epc;
    for (int i = 0; i < 6; i++) begin
      tick(0, 1, 1, 1, 1, 32'h0000_4000 + i);
      chk("R10", "bubble no trap", {31'b0, s_red}, 0);
    end
    tick(0, 0, 0, 0, 0, 0);
    chk("R10", "cause untouched", {28'b0, s_cause}, {28'b0, c0});
    chk("R10", "epc untouched", s_epc, e0);
  endtask

  task automatic t_irq;
    // three clean instructions, commit at c3,c4,c5; irq raised at c3
    tick(1, 0, 0, 0, 0, 0); tick(1, 0, 0, 0, 0, 0); tick(1, 0, 0, 0, 0, 0);
    irq_i = 1;
    tick(0, 0, 0, 0, 0, 32'h0000_5000);
    chk("R11", "no trap 0 edges", {31'b0, s_red}, 0);
    tick(0, 0, 0, 0, 0, 32'h0000_5004);
    chk("R11", "no trap 1 edge", {31'b0, s_red}, 0);
    tick(0, 0, 0, 0, 0, 32'h0000_5008);
    chk("R11", "trap after 2 edges", {31'b0, s_red}, 1);
    tick(0, 0, 0, 0, 0, 0);
    chk("R5", "irq code", {28'b0, s_cause}, 8);
    chk("R6", "irq epc", s_epc, 32'h0000_5008);
    // irq stays high, only bubbles reach commit: it waits
    for (int i = 0; i < 5; i++) begin
      tick(0, 0, 0, 0, 0, 0);
      chk("R11", "waits on bubble", {31'b0, s_red}, 0);
    end
    // valid instruction with a fetch fault: interrupt wins
    tick(1, 1, 0, 0, 0, 0); tick(0, 0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 32'h0000_6000);
    chk("R4", "trap", {31'b0, s_red}, 1);
    irq_i = 0;
    tick(0, 0, 0, 0, 0, 0);
    chk("R4", "interrupt over fault", {28'b0, s_cause}, 8);
    chk("R4", "epc", s_epc, 32'h0000_6000);
    idle(4);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    t_one(0, 32'h0000_1000);
    t_one(1, 32'h0000_1004);
    t_one(2, 32'h0000_1008);
    t_one(3, 32'h0000_100c);
    t_priority();
    t_flush();
    t_bubble();
    t_irq();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule